// File: doc/BRIEF.md
# Configuration Request Engine for a Root Port

This block sits behind a small register port and turns software register writes into single configuration read or write requests toward the link. Software first writes the target register with the bus, device, function and register offset. It then writes the control register with the send bit set and a header kind chosen: kind 0 when the target bus sits directly below the root bus, kind 1 otherwise. The engine issues one dword request on a valid/ready request channel and waits for a completion carrying a status and data. It then returns the read data in the data register and records any failure in a sticky error register that is cleared by writing ones.

Accesses whose bus number equals the programmed root bus never reach the link. They are served from a small local configuration store, and only device 0 answers there. Byte and halfword writes are built by the engine itself: it reads the containing dword, merges the new lanes and writes the dword back. The remote path and the local path both work this way. A completion timer ends a request that never completes. Writing zero to the control register abandons any access in progress.

Top module: `cfg_req_engine`

## Requirements
- R1: After reset, every readable register returns zero, except the control register's busy bit, which also reads 0. `req_valid` is low.
- R2: A remote access raises `req_valid` with `req_addr` equal to the target register with bits 1:0 cleared. The target register holds bus in bits 31:24, device in bits 23:19, function in bits 18:16 and register offset in bits 11:0. The engine holds the request until `req_ready` and has at most one request outstanding.
- R3: The control register launches an access when written with bit 31 set. Bit 8 selects the header kind (1 = kind 1, 0 = kind 0), and this bit is driven on `req_type1`. Bit 0 selects write (1) or read (0). Bits 2:1 select the size: 00 dword, 01 byte, 10 halfword.
- R4: A dword write sends one request with `req_write` high and `req_data` equal to the data register. A successful dword read loads the completion data into the data register.
- R5: A byte or halfword write first issues a dword read. It then issues a dword write in which the data register's low byte replaces byte lane offset[1:0], or its low halfword replaces halfword lane offset[1]. All other lanes keep the value that was read. Local accesses merge in the same way.
- R6: A completion with status 1 (unsupported request) sets bit 4 of the error register. The register is write-one-to-clear, so writing back the value read from it clears it.
- R7: A completion with status 2 or 3 (completer or master abort) sets bit 5 of the error register, which marks the access as device-not-found.
- R8: If no completion arrives within TIMEOUT_CYCLES cycles of the request being accepted, bit 6 of the error register is set and the access ends. A read that fails through timeout, unsupported request, abort or absent local device leaves all-ones in the data register.
- R9: Control bit 31 reads as busy from launch until the access ends. While busy, a control write that is neither a launch nor zero is ignored. A launch while busy is also ignored, and so are writes to the target and data registers.
- R10: Writing zero to the control register returns the engine to idle on the next cycle.
- R11: When the target bus equals the root bus register (address 4, bits 7:0), no request is issued. Device 0 reads and writes the local store, whose dword 0 resets to LOCAL_ID. Any other device sets error bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 target, 1 control, 2 data, 3 error, 4 root bus |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | output | 1 | Request valid toward the link |
| req_ready | input | 1 | Link accepts the request |
| req_write | output | 1 | Request is a write |
| req_type1 | output | 1 | Request uses header kind 1 |
| req_addr | output | 32 | Dword-aligned target address |
| req_data | output | 32 | Write data of the request |
| cpl_valid | input | 1 | Completion strobe |
| cpl_status | input | 2 | 0 success, 1 unsupported, 2 completer abort, 3 master abort |
| cpl_data | input | 32 | Completion read data |

## Verification
The hardest states to reach are the two that depend on time passing with nothing happening. One is the window in which an access is stalled waiting for a completion. The other is the exact cycle at which the timer gives up. The bench link model can be told to stay silent. This lets stimulus park the engine in its waiting state, where it tries an extra launch, a plain control write and a zero write. It then counts edges to confirm busy holds through TIMEOUT_CYCLES cycles and drops on the next. Read-modify-write is made observable by seeding the model's remote dwords and checking both the request pair and the merged result it stores.

// File: rtl/cfg_req_pkg.sv
package cfg_req_pkg;

   localparam int unsigned DW = 32;

   typedef enum logic [1:0] {
      SZ_DWORD = 2'b00,
      SZ_BYTE  = 2'b01,
      SZ_HALF  = 2'b10,
      SZ_RSVD  = 2'b11
   } acc_size_e;

   typedef enum logic [1:0] {
      CPL_OK = 2'd0,
      CPL_UR = 2'd1,
      CPL_CA = 2'd2,
      CPL_MA = 2'd3
   } cpl_stat_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_REQ,
      ST_WAIT,
      ST_LOCAL
   } eng_state_e;

   typedef struct packed {
      logic      write;
      logic      type1;
      acc_size_e size;
   } op_t;

   localparam logic [2:0] RA_TGT  = 3'd0;
   localparam logic [2:0] RA_CTRL = 3'd1;
   localparam logic [2:0] RA_DATA = 3'd2;
   localparam logic [2:0] RA_ERR  = 3'd3;
   localparam logic [2:0] RA_ROOT = 3'd4;

   localparam int unsigned ERR_UR_BIT  = 4;
   localparam int unsigned ERR_ABT_BIT = 5;
   localparam int unsigned ERR_TMO_BIT = 6;

endpackage

// File: rtl/cfg_lane_merge.sv
module cfg_lane_merge
   import cfg_req_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input  logic [8*LANES-1:0] old_dw,
   input  logic [8*LANES-1:0] new_val,
   input  logic [1:0]         off,
   input  acc_size_e          size,
   output logic [8*LANES-1:0] merged
);
   localparam int unsigned W = 8*LANES;

   logic [W-1:0]     shifted;
   logic [LANES-1:0] lane_en;

   initial begin
      assert (LANES == 4) else $error("cfg_lane_merge: LANES must be 4");
   end

   always_comb begin
      unique case (size)
         SZ_BYTE: shifted = new_val << (8 * off);
         SZ_HALF: shifted = new_val << (16 * off[1]);
         default: shifted = new_val;
      endcase
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_comb begin
         unique case (size)
            SZ_BYTE: lane_en[l] = (off == 2'(l));
            SZ_HALF: lane_en[l] = (off[1] == l[1]);
            default: lane_en[l] = 1'b1;
         endcase
      end
      assign merged[8*l +: 8] = lane_en[l] ? shifted[8*l +: 8] : old_dw[8*l +: 8];
   end

endmodule

// File: rtl/cfg_cpl_timer.sv
module cfg_cpl_timer #(
   parameter int unsigned TIMEOUT_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (TIMEOUT_CYCLES >= 2) else $error("cfg_cpl_timer: TIMEOUT_CYCLES too small");
   end

   assign expire = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (run && !expire)   cnt_q <= cnt_q + 1'b1;
      else                       cnt_q <= '0;
   end

   // R8: the wait counter never passes its limit
   a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/cfg_local_space.sv
module cfg_local_space #(
   parameter int unsigned WORDS    = 16,
   parameter logic [31:0] LOCAL_ID = 32'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [9:0]  off_dw,
   input  logic [31:0] wdata,
   output logic [31:0] rdata
);
   localparam int unsigned LIW = (WORDS > 1) ? $clog2(WORDS) : 1;

   logic [WORDS-1:0][31:0] words;
   logic                   in_range;
   logic [LIW-1:0]         idx;

   initial begin
      assert (WORDS >= 1 && WORDS <= 1024) else $error("cfg_local_space: WORDS out of range");
   end

   assign in_range = ({22'b0, off_dw} < WORDS);
   assign idx      = off_dw[LIW-1:0];
   assign rdata    = in_range ? words[idx] : '0;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [31:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    word_q <= (w == 0) ? LOCAL_ID : 32'h0;
         else if (we && in_range && idx == LIW'(w))     word_q <= wdata;
      end
      assign words[w] = word_q;
   end

endmodule

// File: rtl/cfg_req_engine.sv
module cfg_req_engine
   import cfg_req_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYCLES = 64,
   parameter int unsigned LOCAL_WORDS    = 16,
   parameter logic [31:0] LOCAL_ID       = 32'h1234_ABCD
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        req_valid,
   input  logic        req_ready,
   output logic        req_write,
   output logic        req_type1,
   output logic [31:0] req_addr,
   output logic [31:0] req_data,
   input  logic        cpl_valid,
   input  logic [1:0]  cpl_status,
   input  logic [31:0] cpl_data
);
   localparam logic [31:0] ALL_ONES = '1;

   eng_state_e  state_q;
   op_t         op_q;
   logic [31:0] tgt_q, data_q, wbuf_q;
   logic [7:0]  root_q;
   logic [2:0]  err_q;     // [0] unsupported, [1] not found, [2] timeout
   logic        rmw_wr_q;

   logic busy, wr_ctrl, ctrl_clear, launch, is_local, sub_wr, dev_zero;
   logic tmr_run, tmr_expire, loc_we;
   logic [31:0] loc_rdata, merge_old, merged, loc_wdata;
   logic [2:0]  err_set, err_w1c;

   assign busy       = (state_q != ST_IDLE);
   assign wr_ctrl    = reg_we && (reg_addr == RA_CTRL);
   assign ctrl_clear = wr_ctrl && (reg_wdata == 32'h0);
   assign launch     = wr_ctrl && reg_wdata[31] && !busy;
   assign is_local   = (tgt_q[31:24] == root_q);
   assign dev_zero   = (tgt_q[23:19] == 5'd0);
   assign sub_wr     = op_q.write && (op_q.size == SZ_BYTE || op_q.size == SZ_HALF);

   assign merge_old  = (state_q == ST_LOCAL) ? loc_rdata : cpl_data;

   cfg_lane_merge #(.LANES(4)) u_merge (
      .old_dw  (merge_old),
      .new_val (data_q),
      .off     (tgt_q[1:0]),
      .size    (op_q.size),
      .merged  (merged)
   );

   assign tmr_run = (state_q == ST_WAIT) && !cpl_valid && !ctrl_clear;

   cfg_cpl_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (tmr_run),
      .expire (tmr_expire)
   );

   assign loc_we    = (state_q == ST_LOCAL) && op_q.write && dev_zero && !ctrl_clear;
   assign loc_wdata = sub_wr ? merged : data_q;

   cfg_local_space #(.WORDS(LOCAL_WORDS), .LOCAL_ID(LOCAL_ID)) u_local (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (loc_we),
      .off_dw (tgt_q[11:2]),
      .wdata  (loc_wdata),
      .rdata  (loc_rdata)
   );

   // request channel
   assign req_valid = (state_q == ST_REQ);
   assign req_write = op_q.write && (!sub_wr || rmw_wr_q);
   assign req_type1 = op_q.type1;
   assign req_addr  = {tgt_q[31:2], 2'b00};
   assign req_data  = wbuf_q;

   // error flags raised by the sequencer this cycle
   always_comb begin
      err_set = 3'b000;
      if (!ctrl_clear) begin
         if (state_q == ST_LOCAL && !dev_zero) err_set[1] = 1'b1;
         if (state_q == ST_WAIT) begin
            if (cpl_valid) begin
               if (cpl_stat_e'(cpl_status) == CPL_UR)      err_set[0] = 1'b1;
               else if (cpl_stat_e'(cpl_status) != CPL_OK) err_set[1] = 1'b1;
            end else if (tmr_expire) begin
               err_set[2] = 1'b1;
            end
         end
      end
   end

   assign err_w1c = (reg_we && reg_addr == RA_ERR) ?
                    {reg_wdata[ERR_TMO_BIT], reg_wdata[ERR_ABT_BIT], reg_wdata[ERR_UR_BIT]} : 3'b000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= '0;
      else        err_q <= (err_q & ~err_w1c) | err_set;
   end

   // software-owned registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q  <= '0;
         root_q <= '0;
      end else if (reg_we && !busy) begin
         if (reg_addr == RA_TGT)  tgt_q  <= reg_wdata;
         if (reg_addr == RA_ROOT) root_q <= reg_wdata[7:0];
      end
   end

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         op_q     <= '0;
         data_q   <= '0;
         wbuf_q   <= '0;
         rmw_wr_q <= 1'b0;
      end else if (ctrl_clear) begin
         state_q  <= ST_IDLE;
         rmw_wr_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (reg_we && reg_addr == RA_DATA) data_q <= reg_wdata;
               if (launch) begin
                  op_q     <= '{write: reg_wdata[0], type1: reg_wdata[8],
                                size: acc_size_e'(reg_wdata[2:1])};
                  wbuf_q   <= data_q;
                  rmw_wr_q <= 1'b0;
                  state_q  <= is_local ? ST_LOCAL : ST_REQ;
               end
            end
            ST_LOCAL: begin
               if (!dev_zero) begin
                  if (!op_q.write) data_q <= ALL_ONES;
               end else if (!op_q.write) begin
                  data_q <= loc_rdata;
               end
               state_q <= ST_IDLE;
            end
            ST_REQ: begin
               if (req_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (cpl_valid) begin
                  if (cpl_stat_e'(cpl_status) == CPL_OK) begin
                     if (sub_wr && !rmw_wr_q) begin
                        wbuf_q   <= merged;
                        rmw_wr_q <= 1'b1;
                        state_q  <= ST_REQ;
                     end else begin
                        if (!op_q.write) data_q <= cpl_data;
                        state_q <= ST_IDLE;
                     end
                  end else begin
                     if (!op_q.write) data_q <= ALL_ONES;
                     state_q <= ST_IDLE;
                  end
               end else if (tmr_expire) begin
                  if (!op_q.write) data_q <= ALL_ONES;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // register readback
   always_comb begin
      unique case (reg_addr)
         RA_TGT:  reg_rdata = tgt_q;
         RA_CTRL: reg_rdata = {busy, 22'b0, op_q.type1, 5'b0, op_q.size, op_q.write};
         RA_DATA: reg_rdata = data_q;
         RA_ERR:  reg_rdata = {25'b0, err_q, 4'b0};
         RA_ROOT: reg_rdata = {24'b0, root_q};
         default: reg_rdata = '0;
      endcase
   end

   // R2: a pending request holds its address and data until accepted
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready && !ctrl_clear |=> req_valid && $stable(req_addr) && $stable(req_data));

   // R9: the latched access is frozen while busy
   a_r9_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !ctrl_clear |=> $stable(op_q) && $stable(tgt_q));

   // R10: a zero control write idles the engine
   a_r10_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_clear |=> !busy && !req_valid);

   // R11: a root-bus launch never reaches the link
   a_r11_local_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      launch && is_local |=> !req_valid);

   // R6: the unsupported flag stays until written with a one
   a_r6_ur_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_q[0] && !err_w1c[0] |=> err_q[0]);

   // R5: a merge write only follows a successful read phase
   a_r5_rmw_order: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && sub_wr |-> rmw_wr_q);

endmodule

// File: tb/cfg_req_engine_tb.sv
module cfg_req_engine_tb;
   localparam int unsigned TMO = 20;
   localparam logic [31:0] LID = 32'h1234_ABCD;
   localparam logic [31:0] GO = 32'h8000_0000, T1 = 32'h100, WR = 32'h1, SZB = 32'h2, SZH = 32'h4;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        req_valid, req_ready = 1'b1, req_write, req_type1;
   logic [31:0] req_addr, req_data;
   logic        cpl_valid = 1'b0;
   logic [1:0]  cpl_status = 2'd0;
   logic [31:0] cpl_data = '0;

   cfg_req_engine #(.TIMEOUT_CYCLES(TMO), .LOCAL_WORDS(8), .LOCAL_ID(LID)) u_dut (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .req_valid, .req_ready, .req_write, .req_type1, .req_addr, .req_data,
      .cpl_valid, .cpl_status, .cpl_data
   );

   always #10 clk = ~clk;

   int n_chk = 0, n_err = 0, overlap = 0;

   // behavioural link-side model: remote dwords, request log
   logic [31:0] rmem [logic [31:0]];
   int          req_cnt = 0;
   logic [31:0] last_addr, last_data, pend_addr, pend_data;
   logic        last_write, last_type1, pend_write;
   bit          pend = 0, silent = 0;
   int          pend_left = 0, rsp_delay = 2;
   logic [1:0]  rsp_status = 2'd0;

   always @(negedge clk) begin
      cpl_valid = 1'b0;
      if (rst_n && req_valid && pend) overlap++;
      if (pend) begin
         if (pend_left <= 1) begin
            cpl_valid  = 1'b1;
            cpl_status = rsp_status;
            cpl_data   = rmem.exists(pend_addr) ? rmem[pend_addr] : 32'h0;
            if (pend_write && rsp_status == 2'd0) rmem[pend_addr] = pend_data;
            pend = 0;
         end else pend_left--;
      end
      if (rst_n && req_valid && req_ready && !cpl_valid) begin
         req_cnt++;
         last_addr = req_addr; last_data = req_data;
         last_write = req_write; last_type1 = req_type1;
         if (!silent) begin
            pend = 1; pend_left = rsp_delay;
            pend_addr = req_addr; pend_data = req_data; pend_write = req_write;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] c;
      for (int i = 0; i < 200; i++) begin
         rd(3'd1, c);
         if (!c[31]) return;
         @(negedge clk);
      end
      chk(1'b0, "R9 busy never cleared", 32'h1, 32'h0);
   endtask

   function automatic logic [31:0] tgt(input int b, input int d, input int f, input int off);
      return (32'(b) << 24) | (32'(d) << 19) | (32'(f) << 16) | 32'(off);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int          c0;
      rmem[32'h0108_0010] = 32'hDEAD_BEEF;
      rmem[32'h0205_0040] = 32'h0BAD_CAFE;
      rmem[32'h0108_0014] = 32'h5566_7788;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v);
         chk(v == 0, "R1 register reset", v, 32'h0);
      end
      chk(req_valid == 0, "R1 req_valid low", 32'(req_valid), 32'h0);

      // R2 R3 R4 kind-0 dword read
      wr(3'd0, tgt(1, 1, 0, 16'h010));
      wr(3'd1, GO);
      wait_idle();
      chk(last_addr == 32'h0108_0010, "R2 request address", last_addr, 32'h0108_0010);
      chk(last_type1 == 0 && last_write == 0, "R3 kind0 read", {30'b0, last_type1, last_write}, 32'h0);
      rd(3'd2, v);
      chk(v == 32'hDEAD_BEEF, "R4 read data", v, 32'hDEAD_BEEF);

      // R3 kind-1 read, unaligned offset drops low bits (R2)
      wr(3'd0, tgt(2, 0, 5, 16'h042));
      wr(3'd1, GO | T1);
      wait_idle();
      chk(last_addr == 32'h0205_0040, "R2 dword aligned", last_addr, 32'h0205_0040);
      chk(last_type1 == 1, "R3 kind1 select", 32'(last_type1), 32'h1);
      rd(3'd2, v);
      chk(v == 32'h0BAD_CAFE, "R4 kind1 read data", v, 32'h0BAD_CAFE);

      // R4 dword write
      c0 = req_cnt;
      wr(3'd0, tgt(1, 2, 0, 16'h020));
      wr(3'd2, 32'h600D_F00D);
      wr(3'd1, GO | WR);
      wait_idle();
      chk(req_cnt == c0 + 1 && last_write == 1, "R4 single write req", 32'(req_cnt - c0), 32'h1);
      chk(rmem[32'h0110_0020] == 32'h600D_F00D, "R4 write data", rmem[32'h0110_0020], 32'h600D_F00D);

      // R5 byte write at offset 3
      rmem[32'h0108_0010] = 32'h1122_3344;
      c0 = req_cnt;
      wr(3'd0, tgt(1, 1, 0, 16'h013));
      wr(3'd2, 32'h0000_00A5);
      wr(3'd1, GO | WR | SZB);
      wait_idle();
      chk(req_cnt == c0 + 2, "R5 byte rmw two requests", 32'(req_cnt - c0), 32'h2);
      chk(rmem[32'h0108_0010] == 32'hA522_3344, "R5 byte merge", rmem[32'h0108_0010], 32'hA522_3344);

      // R5 halfword write at offset 2
      wr(3'd0, tgt(1, 1, 0, 16'h016));
      wr(3'd2, 32'h0000_BEEF);
      wr(3'd1, GO | WR | SZH);
      wait_idle();
      chk(rmem[32'h0108_0014] == 32'hBEEF_7788, "R5 half merge", rmem[32'h0108_0014], 32'hBEEF_7788);

      // R6 unsupported request, then write-one-to-clear
      rsp_status = 2'd1;
      wr(3'd0, tgt(1, 3, 0, 16'h000));
      wr(3'd1, GO);
      wait_idle();
      rd(3'd3, v);
      chk(v == 32'h10, "R6 unsupported flag", v, 32'h10);
      rd(3'd2, v);
      chk(v == 32'hFFFF_FFFF, "R8 failed read all ones", v, 32'hFFFF_FFFF);
      rd(3'd3, v);
      wr(3'd3, v);
      rd(3'd3, v);
      chk(v == 32'h0, "R6 w1c clears", v, 32'h0);

      // R7 completer abort
      rsp_status = 2'd2;
      wr(3'd1, GO);
      wait_idle();
      rd(3'd3, v);
      chk(v == 32'h20, "R7 abort flag", v, 32'h20);
      wr(3'd3, 32'h20);
      rsp_status = 2'd3;
      wr(3'd1, GO);
      wait_idle();
      rd(3'd3, v);
      chk(v == 32'h20, "R7 master abort flag", v, 32'h20);
      wr(3'd3, 32'h20);
      rsp_status = 2'd0;

      // R8 R9 timeout with ignored launch while waiting
      silent = 1;
      c0 = req_cnt;
      wr(3'd0, tgt(1, 1, 0, 16'h010));
      wr(3'd1, GO);
      wr(3'd1, GO | T1 | WR);
      wr(3'd0, 32'h0);
      rd(3'd1, v);
      chk(v == 32'h8000_0000, "R9 launch while busy ignored", v, 32'h8000_0000);
      rd(3'd0, v);
      chk(v == tgt(1, 1, 0, 16'h010), "R9 target write while busy ignored", v, tgt(1, 1, 0, 16'h010));
      repeat (TMO - 3) @(negedge clk);
      rd(3'd1, v);
      chk(v[31] == 1, "R8 busy through timeout window", v, 32'h8000_0000);
      @(negedge clk); @(negedge clk);
      rd(3'd1, v);
      chk(v[31] == 0, "R8 idle after timeout", v, 32'h0);
      rd(3'd3, v);
      chk(v == 32'h40, "R8 timeout flag", v, 32'h40);
      rd(3'd2, v);
      chk(v == 32'hFFFF_FFFF, "R8 timeout data", v, 32'hFFFF_FFFF);
      chk(req_cnt == c0 + 1, "R9 one request only", 32'(req_cnt - c0), 32'h1);
      wr(3'd3, 32'h40);

      // R10 zero control write abandons
      wr(3'd1, GO);
      wr(3'd1, 32'h0);
      rd(3'd1, v);
      chk(v[31] == 0, "R10 zero write idles", v, 32'h0);
      rd(3'd3, v);
      chk(v == 32'h0, "R10 no error after abandon", v, 32'h0);
      silent = 0;

      // R11 local space, root bus 0
      c0 = req_cnt;
      wr(3'd0, tgt(0, 0, 0, 16'h004));
      wr(3'd2, 32'hCAFE_F00D);
      wr(3'd1, GO | WR);
      wait_idle();
      wr(3'd2, 32'h0);
      wr(3'd1, GO);
      wait_idle();
      rd(3'd2, v);
      chk(v == 32'hCAFE_F00D, "R11 local write/read", v, 32'hCAFE_F00D);
      wr(3'd0, tgt(0, 0, 0, 16'h001));
      wr(3'd2, 32'h5A);
      wr(3'd1, GO | WR | SZB);
      wait_idle();
      wr(3'd1, GO);
      wait_idle();
      rd(3'd2, v);
      chk(v == 32'h1234_5ACD, "R5 R11 local byte merge", v, 32'h1234_5ACD);
      wr(3'd0, tgt(0, 3, 0, 16'h000));
      wr(3'd1, GO);
      wait_idle();
      rd(3'd3, v);
      chk(v == 32'h20, "R11 absent local device", v, 32'h20);
      rd(3'd2, v);
      chk(v == 32'hFFFF_FFFF, "R11 absent device data", v, 32'hFFFF_FFFF);
      chk(req_cnt == c0, "R11 no link requests", 32'(req_cnt - c0), 32'h0);

      // R11 root bus moved: bus 0 now remote
      wr(3'd3, 32'h20);
      wr(3'd4, 32'h7);
      rd(3'd4, v);
      chk(v == 32'h7, "R11 root register", v, 32'h7);
      wr(3'd0, tgt(0, 0, 0, 16'h000));
      wr(3'd1, GO);
      wait_idle();
      chk(req_cnt == c0 + 1, "R11 non-root bus goes remote", 32'(req_cnt - c0), 32'h1);

      chk(overlap == 0, "R2 single outstanding request", 32'(overlap), 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule